// File: doc/BRIEF.md
# Pipelined Signed Adder Tree

This block reduces a packed vector of N signed words to one signed total through a tree of registered adder stages. Each stage combines groups of FANIN operands, either two or four, and registers the partial sums. So the number of stages, and the latency, is the base-FANIN logarithm of N. Every partial sum keeps the input word width and wraps modulo 2^W.

Alongside the data, each stage keeps a sticky overflow bit. It is the OR of the overflow of every addition made in that stage and the overflow bit of the stage before it. An overflow flag supplied by an upstream block enters at the first stage, so it reaches the output flag too. The output sum and the output flag always belong to the same input set.

A valid bit travels through a shift register as long as the tree latency. The output strobe marks exactly the results of accepted inputs. Choosing FANIN trades pipeline depth against the adder depth in each stage. A configuration in which N is not a power of FANIN, or FANIN is not 2 or 4, is rejected at elaboration.

Top module: `sum_tree`

## Requirements
- R1: When `out_valid` is high, `out_sum` equals the sum of the N input words of the corresponding accepted set, wrapped to W bits (two's complement, modulo 2^W).
- R2: A set accepted on a clock edge with `in_valid` high appears on the outputs exactly L edges later, where L = log base FANIN of N (4 for N=16 with FANIN=2, 2 for N=16 with FANIN=4).
- R3: `out_valid` is high exactly L cycles after each accepted set and low otherwise. Back-to-back sets on consecutive cycles give back-to-back results.
- R4: An addition overflows when its two operands share a sign bit and the sum's sign bit differs from it. `out_ovf` is high for a result if any addition made for that set in the tree overflowed. Operands are paired in index order: word 2k with word 2k+1, and partial sums likewise.
- R5: If `in_ovf` is high when a set is accepted, `out_ovf` is high for that set's result even when no addition overflows.
- R6: The overflow flag of one set does not leak into the result of a set accepted one cycle earlier or later.
- R7: A synchronous active-high `rst` clears all valid and overflow state. Sets in flight at reset never produce `out_valid`.
- R8: With FANIN=4, an overflow in either first-level pairwise addition inside a stage (words 4k+0 plus 4k+1, or 4k+2 plus 4k+3) sets the flag, even when the stage's final sum comes out mathematically correct after wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the current input set as accepted |
| in_words | input | N*W | N signed words; word i at bits [i*W +: W] |
| in_ovf | input | 1 | Upstream overflow flag for the current set |
| out_valid | output | 1 | Result strobe |
| out_sum | output | W | Wrapped signed total |
| out_ovf | output | 1 | Sticky overflow flag for the result |

## Verification
The bench builds two copies of the block from the same stimulus, both with N=16 and W=16. One uses FANIN=2 (four stages) and the other FANIN=4 (two stages), so both latencies and both stage shapes are checked against one expected-value model. The FANIN=4 copy is what exposes overflows inside a stage that the wrapped stage sum hides. The pairing into four pipeline stages exposes flag carrying across several registers. Back-to-back and gapped traffic, invalid cycles carrying `in_ovf`, and a reset with sets in flight show that the flags and strobes stay tied to their own sets.

// File: rtl/sum_tree.sv
module sum_tree #(
  parameter int N     = 16,
  parameter int W     = 16,
  parameter int FANIN = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_words,
  input  logic           in_ovf,
  output logic           out_valid,
  output logic [W-1:0]   out_sum,
  output logic           out_ovf
);

  localparam int STEP   = (FANIN == 4) ? 2 : 1;
  localparam int LEVELS = $clog2(N) / STEP;

  function automatic int base(input int l);
    int o = 0;
    int n = N;
    for (int k = 0; k < l; k++) begin
      o += n;
      n = n / FANIN;
    end
    return o;
  endfunction

  localparam int NODES = base(LEVELS) + 1;

  if (!(FANIN == 2 || FANIN == 4) || N < FANIN || N != (1 << (LEVELS * STEP))) begin : bad_cfg
    $error("sum_tree: FANIN must be 2 or 4 and N a power of FANIN");
  end

  function automatic logic add_ov(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [W-1:0] s);
    return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
  endfunction

  logic [NODES*W-1:0] node;
  logic [LEVELS:0]    ovc;
  logic [LEVELS-1:0]  vld;

  assign node[N*W-1:0] = in_words;
  assign ovc[0]        = in_ovf;

  for (genvar l = 0; l < LEVELS; l++) begin : lvl
    localparam int IB   = base(l);
    localparam int OB   = base(l + 1);
    localparam int NOUT = (OB - IB) / FANIN;

    logic [NOUT-1:0] gov;
    logic            ovf_q;

    for (genvar g = 0; g < NOUT; g++) begin : grp
      logic [W-1:0] s, q;
      logic         ov;

      if (FANIN == 2) begin : f2
        logic [W-1:0] a, b;
        assign a  = node[(IB + 2*g) * W +: W];
        assign b  = node[(IB + 2*g + 1) * W +: W];
        assign s  = a + b;
        assign ov = add_ov(a, b, s);
      end else begin : f4
        logic [W-1:0] a, b, c, d, p0, p1;
        assign a  = node[(IB + 4*g) * W +: W];
        assign b  = node[(IB + 4*g + 1) * W +: W];
        assign c  = node[(IB + 4*g + 2) * W +: W];
        assign d  = node[(IB + 4*g + 3) * W +: W];
        assign p0 = a + b;
        assign p1 = c + d;
        assign s  = p0 + p1;
        assign ov = add_ov(a, b, p0) | add_ov(c, d, p1) | add_ov(p0, p1, s);
      end

      always_ff @(posedge clk) q <= s;

      assign node[(OB + g) * W +: W] = q;
      assign gov[g] = ov;
    end

    always_ff @(posedge clk) begin
      if (rst) ovf_q <= 1'b0;
      else     ovf_q <= ovc[l] | (|gov);
    end

    assign ovc[l+1] = ovf_q;

    // R4
    stage_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovc[l] |=> ovc[l+1]);
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else begin
      vld[0] <= in_valid;
      for (int k = 1; k < LEVELS; k++) vld[k] <= vld[k-1];
    end
  end

  assign out_valid = vld[LEVELS-1];
  assign out_sum   = node[(NODES-1) * W +: W];
  assign out_ovf   = ovc[LEVELS];

  int since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 0;
    else if (since_rst < LEVELS) since_rst <= since_rst + 1;
  end

  // R3
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= LEVELS) |-> (out_valid == $past(in_valid, LEVELS)));

  // R5
  ovf_in_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= LEVELS && $past(in_ovf, LEVELS)) |-> out_ovf);

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_ovf));

endmodule

// File: tb/sum_tree_test.sv
module sum_tree_test;
  localparam int N = 16;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ovf = 1'b0;
  logic [N*W-1:0] in_words = '0;
  logic           v2, o2, v4, o4;
  logic [W-1:0]   s2, s4;

  always #2 clk = ~clk;

  sum_tree #(.N(N), .W(W), .FANIN(2)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_words(in_words), .in_ovf(in_ovf),
    .out_valid(v2), .out_sum(s2), .out_ovf(o2));

  sum_tree #(.N(N), .W(W), .FANIN(4)) uut_f4 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_words(in_words), .in_ovf(in_ovf),
    .out_valid(v4), .out_sum(s4), .out_ovf(o4));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] sum;
    logic         ov;
    int           due;
    string        tag;
  } item_t;

  item_t q2[$];
  item_t q4[$];

  function automatic logic ovf(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] s);
    return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
  endfunction

  function automatic item_t model(input logic [N*W-1:0] v, input logic ovi, input int f,
                                  input int due, input string tag);
    logic [W-1:0] a [N];
    logic [W-1:0] p0, p1, s;
    logic ov;
    int n;
    item_t it;
    ov = ovi;
    n = N;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    while (n > 1) begin
      for (int g = 0; g < n / f; g++) begin
        if (f == 2) begin
          s = a[2*g] + a[2*g+1];
          ov |= ovf(a[2*g], a[2*g+1], s);
        end else begin
          p0 = a[4*g] + a[4*g+1];
          p1 = a[4*g+2] + a[4*g+3];
          s  = p0 + p1;
          ov |= ovf(a[4*g], a[4*g+1], p0) | ovf(a[4*g+2], a[4*g+3], p1) | ovf(p0, p1, s);
        end
        a[g] = s;
      end
      n = n / f;
    end
    it.sum = a[0];
    it.ov  = ov;
    it.due = due;
    it.tag = tag;
    return it;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [N*W-1:0] d, input logic oi, input string tag);
    @(negedge clk);
    in_valid = v;
    in_words = d;
    in_ovf   = oi;
    if (v) begin
      q2.push_back(model(d, oi, 2, cyc + 4, tag));
      q4.push_back(model(d, oi, 4, cyc + 2, tag));
    end
  endtask

  always @(negedge clk) begin : mon2
    logic due;
    item_t it;
    if (!rst) begin
      due = (q2.size() > 0) && (q2[0].due == cyc);
      if (due || v2) chk("R3", "f2 out_valid", {31'b0, v2}, {31'b0, due});
      if (due) begin
        it = q2.pop_front();
        if (v2) begin
          chk("R1", "f2 out_sum", {16'b0, s2}, {16'b0, it.sum});
          chk(it.tag, "f2 out_ovf", {31'b0, o2}, {31'b0, it.ov});
        end
      end
    end
  end

  always @(negedge clk) begin : mon4
    logic due;
    item_t it;
    if (!rst) begin
      due = (q4.size() > 0) && (q4[0].due == cyc);
      if (due || v4) chk("R2", "f4 out_valid", {31'b0, v4}, {31'b0, due});
      if (due) begin
        it = q4.pop_front();
        if (v4) begin
          chk("R1", "f4 out_sum", {16'b0, s4}, {16'b0, it.sum});
          chk(it.tag, "f4 out_ovf", {31'b0, o4}, {31'b0, it.ov});
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [N*W-1:0] d;
    repeat (3) @(negedge clk);
    // R7: state clear while in reset
    chk("R7", "f2 valid in reset", {31'b0, v2}, 32'd0);
    chk("R7", "f2 ovf in reset", {31'b0, o2}, 32'd0);
    chk("R7", "f4 valid in reset", {31'b0, v4}, 32'd0);
    chk("R7", "f4 ovf in reset", {31'b0, o4}, 32'd0);
    rst = 1'b0;

    // R1, R2: ascending 1..16 gives 136
    for (int i = 0; i < N; i++) d[i*W +: W] = 16'(i + 1);
    drive(1'b1, d, 1'b0, "R4");
    drive(1'b0, '0, 1'b0, "R4");
    repeat (5) drive(1'b0, '0, 1'b0, "R4");

    // R1: mixed signs, all -1
    d = '1;
    drive(1'b1, d, 1'b0, "R4");
    for (int i = 0; i < N; i++) d[i*W +: W] = (i % 2 == 0) ? 16'(-300 * i) : 16'(17 * i);
    drive(1'b1, d, 1'b0, "R4");

    // R4: leaf overflow on the first pair
    d = '0;
    d[0*W +: W] = 16'h7FFF;
    d[1*W +: W] = 16'h7FFF;
    drive(1'b1, d, 1'b0, "R4");

    // R5: upstream flag with harmless data, R6: clean neighbours
    drive(1'b1, '0, 1'b0, "R6");
    drive(1'b1, '0, 1'b1, "R5");
    drive(1'b1, '0, 1'b0, "R6");

    // R6: invalid cycles carrying the upstream flag between valid sets
    drive(1'b0, '1, 1'b1, "R6");
    drive(1'b1, '0, 1'b0, "R6");
    drive(1'b0, '0, 1'b1, "R6");
    drive(1'b1, '0, 1'b0, "R6");

    // R8: inner pair overflows cancel in the wrapped total
    d = '0;
    d[0*W +: W] = 16'h7000;
    d[1*W +: W] = 16'h7000;
    d[2*W +: W] = 16'h9000;
    d[3*W +: W] = 16'h9000;
    drive(1'b1, d, 1'b0, "R8");
    d = '0;
    d[4*W +: W] = 16'h8000;
    d[5*W +: W] = 16'hFFFF;
    d[6*W +: W] = 16'h0001;
    d[7*W +: W] = 16'h7FFF;
    drive(1'b1, d, 1'b0, "R8");

    // R3: back-to-back random sets, small and full range
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < N; i++)
        d[i*W +: W] = (k % 2 == 0) ? 16'($urandom_range(0, 2000)) - 16'd1000 : 16'($urandom);
      drive(1'b1, d, 1'($urandom_range(0, 7) == 0), "R4");
    end
    // R3: gapped traffic
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < N; i++) d[i*W +: W] = 16'($urandom);
      drive(1'($urandom_range(0, 1)), d, 1'($urandom_range(0, 3) == 0), "R4");
    end
    drive(1'b0, '0, 1'b0, "R4");
    repeat (8) @(negedge clk);

    // R7: reset with sets in flight
    for (int k = 0; k < 3; k++) drive(1'b1, '1, 1'b1, "R7");
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_ovf = 1'b0;
    q2.delete();
    q4.delete();
    repeat (2) @(negedge clk);
    chk("R7", "f2 ovf after reset", {31'b0, o2}, 32'd0);
    chk("R7", "f4 ovf after reset", {31'b0, o4}, 32'd0);
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R7", "f2 no stale valid", {31'b0, v2}, 32'd0);
      chk("R7", "f4 no stale valid", {31'b0, v4}, 32'd0);
    end

    drive(1'b1, '0, 1'b1, "R5");
    drive(1'b0, '0, 1'b0, "R5");
    repeat (8) @(negedge clk);
    chk("R3", "f2 results pending", q2.size(), 32'd0);
    chk("R2", "f4 results pending", q4.size(), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule